// File: doc/BRIEF.md
# Permission-Entry Page-Table Walker

This block walks a four-level, radix-512 translation table for an I/O translation unit. It takes one request at a time, made of a virtual address and an access type. For each level it issues one 8-byte read over a simple memory-read port, starting from the table named by a root pointer. It ends with a one-cycle response that carries a physical address and a fault cause.

Besides ordinary pointer and leaf entries, the walker recognises a permission entry, which may stand in place of a normal entry at level 2 or level 3. When the walker meets one, the walk stops there and the address is identity-mapped, so the physical address equals the virtual address. One of sixteen 2-bit descriptors in the entry then decides whether the access is allowed. An invalid descriptor punches a hole in an otherwise identity-mapped region, and any access in that hole faults. Translation caching and the memory controller are not part of this block.

Top module: `pgw_top`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `mem_req_valid` and `resp_valid` are 0.
- R2: A walk starts at `root_ptr` with level 4. The read for level L is issued at table base + 8 × index, where the index is `vaddr[12+9(L-1) +: 9]`. There is exactly one read per level visited, and `mem_req_valid` and `mem_req_addr` hold steady until `mem_rsp_valid` arrives.
- R3: Entry bit 0 is present and bit 1 is kind (1 = permission entry). For a present normal entry above level 1, the next table base is entry bits [47:12] followed by 12 zero bits. A present normal entry at level 1 gives `resp_paddr` = {entry[47:12], vaddr[11:0]} with cause 0 (none).
- R4: An entry whose present bit is 0 ends the walk at once with cause 1 (translation fault), whatever its kind bit says.
- R5: A present permission entry at level 2 ends the walk at once. The descriptor index is `vaddr[20:17]`, and descriptor d sits in entry bits [33+2d:32+2d]. If the access is allowed, `resp_paddr` equals `vaddr`.
- R6: A present permission entry at level 3 ends the walk the same way, but with descriptor index `vaddr[29:26]`.
- R7: A present permission entry at level 1 or level 4 ends the walk with cause 3 (illegal level).
- R8: The descriptor codes are 00 invalid, 01 read-only, 10 read-write and 11 read-execute. The access codes are 00 read, 01 write, 10 execute and 11 reserved. A read is allowed for any descriptor except invalid. A write is allowed only for read-write, and an execute only for read-execute. A reserved access is never allowed. A denied access gives cause 2 (permission fault).
- R9: The response is a single-cycle `resp_valid` pulse. `resp_fault` is 1 exactly when the cause is not 0, and `resp_paddr` is 0 on any fault. While a walk is in progress, `req_ready` is 0 and requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ptr | input | 48 | Base address of the level-4 table, 4 KB aligned |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted on this edge |
| req_vaddr | input | 48 | Virtual address to translate |
| req_access | input | 2 | Access type code |
| mem_req_valid | output | 1 | Table-entry read request |
| mem_req_addr | output | 48 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid, completes the pending read |
| mem_rsp_data | input | 64 | Table entry read back |
| resp_valid | output | 1 | Walk result valid for one cycle |
| resp_paddr | output | 48 | Physical address (0 on a fault) |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_cause | output | 2 | 0 none, 1 translation, 2 permission, 3 illegal level |

## Verification
Directed walks end at each kind of terminal entry: a normal leaf, a non-present entry at each of the four levels, and a permission entry at each level. These separate correct early termination and level legality from a walk that always runs to the bottom. Every descriptor value is crossed with every access code at level 2 and level 3, and the descriptor bits are randomised, so a wrong address slice for the descriptor index or a wrong grant table shows up as a mismatch. Random walks fill the tables with decoy permission entries beside the real slot and vary the read latency. A wrong index, a wrong read count or a read address that moves during a stall therefore changes the result. Some walks keep `req_valid` high with a different address while busy, which shows whether a second request can disturb a walk in progress.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_EXEC  = 2'b10,
      ACC_RSVD  = 2'b11
   } access_e;

   typedef enum logic [1:0] {
      PD_INVALID = 2'b00,
      PD_RO      = 2'b01,
      PD_RW      = 2'b10,
      PD_RX      = 2'b11
   } perm_e;

   typedef enum logic [1:0] {
      CZ_NONE  = 2'b00,
      CZ_XLATE = 2'b01,
      CZ_PERM  = 2'b10,
      CZ_LEVEL = 2'b11
   } cause_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_WALK = 2'b01,
      ST_DONE = 2'b10
   } state_e;

   // grant table: read needs any valid code, write and execute need their own
   function automatic logic perm_grants(perm_e d, access_e a);
      case (a)
         ACC_READ:  return d != PD_INVALID;
         ACC_WRITE: return d == PD_RW;
         ACC_EXEC:  return d == PD_RX;
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/pgw_index_sel.sv
module pgw_index_sel #(
   parameter int ADDR_W    = 48,
   parameter int PAGE_BITS = 12,
   parameter int IDX_W     = 9,
   parameter int LEVELS    = 4,
   parameter int LVL_W     = 3
) (
   input  logic [ADDR_W-1:0] va,
   input  logic [LVL_W-1:0]  level,
   output logic [IDX_W-1:0]  idx
);

   logic [IDX_W-1:0] slice_q [LEVELS];

   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      localparam int LSB = PAGE_BITS + IDX_W * g;
      assign slice_q[g] = va[LSB +: IDX_W];
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < LEVELS; i++) begin
         if (level == LVL_W'(i + 1)) idx = slice_q[i];
      end
   end

endmodule

// File: rtl/pgw_perm_check.sv
module pgw_perm_check
   import pgw_pkg::*;
#(
   parameter int ADDR_W     = 48,
   parameter int PAGE_BITS  = 12,
   parameter int IDX_W      = 9,
   parameter int LVL_W      = 3,
   parameter int NDESC      = 16,
   parameter int PE_MIN_LVL = 2,
   parameter int PE_MAX_LVL = 3
) (
   input  logic [ADDR_W-1:0]  va,
   input  logic [LVL_W-1:0]   level,
   input  logic [2*NDESC-1:0] desc_field,
   input  access_e            access,
   output logic               level_ok,
   output logic               allow
);

   localparam int DSEL_W = $clog2(NDESC);
   localparam int NPE    = PE_MAX_LVL - PE_MIN_LVL + 1;

   logic [DSEL_W-1:0] sel_by_lvl [NPE];

   // the descriptor index is the top DSEL_W bits of the span one entry covers
   for (genvar g = 0; g < NPE; g++) begin : g_pe
      localparam int LSB = PAGE_BITS + IDX_W * (PE_MIN_LVL + g - 1) - DSEL_W;
      assign sel_by_lvl[g] = va[LSB +: DSEL_W];
   end

   logic [DSEL_W-1:0] sel;
   perm_e             desc;

   always_comb begin
      level_ok = 1'b0;
      sel      = '0;
      for (int i = 0; i < NPE; i++) begin
         if (level == LVL_W'(PE_MIN_LVL + i)) begin
            level_ok = 1'b1;
            sel      = sel_by_lvl[i];
         end
      end
      desc = perm_e'(desc_field[{sel, 1'b0} +: 2]);
   end

   assign allow = perm_grants(desc, access);

endmodule

// File: rtl/pgw_walk_fsm.sv
module pgw_walk_fsm
   import pgw_pkg::*;
#(
   parameter int ADDR_W      = 48,
   parameter int PAGE_BITS   = 12,
   parameter int LEVELS      = 4,
   parameter int LVL_W       = 3,
   parameter int ENTRY_W     = 64,
   parameter int PRESENT_BIT = 0,
   parameter int KIND_BIT    = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  root_ptr,
   input  logic               req_valid,
   input  logic [ADDR_W-1:0]  req_vaddr,
   input  access_e            req_access,
   output logic               req_ready,
   output logic               walking,
   input  logic               mem_rsp_valid,
   input  logic [ENTRY_W-1:0] mem_rsp_data,
   input  logic               perm_level_ok,
   input  logic               perm_allow,
   output logic [ADDR_W-1:0]  va_q,
   output access_e            acc_q,
   output logic [LVL_W-1:0]   lvl_q,
   output logic [ADDR_W-1:0]  base_q,
   output logic               resp_valid,
   output logic [ADDR_W-1:0]  resp_paddr,
   output logic               resp_fault,
   output logic [1:0]         resp_cause
);

   state_e               state_q;
   cause_e               cause_q;
   logic [ADDR_W-1:0]    paddr_q;
   logic [ADDR_W-PAGE_BITS-1:0] frame;
   logic                 present, is_pe;

   assign frame   = mem_rsp_data[ADDR_W-1:PAGE_BITS];
   assign present = mem_rsp_data[PRESENT_BIT];
   assign is_pe   = mem_rsp_data[KIND_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cause_q <= CZ_NONE;
         paddr_q <= '0;
         va_q    <= '0;
         acc_q   <= ACC_READ;
         lvl_q   <= '0;
         base_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_vaddr;
                  acc_q   <= req_access;
                  lvl_q   <= LVL_W'(LEVELS);
                  base_q  <= root_ptr;
                  state_q <= ST_WALK;
               end
            end
            ST_WALK: begin
               if (mem_rsp_valid) begin
                  if (!present) begin
                     cause_q <= CZ_XLATE;
                     paddr_q <= '0;
                     state_q <= ST_DONE;
                  end else if (is_pe) begin
                     state_q <= ST_DONE;
                     if (!perm_level_ok) begin
                        cause_q <= CZ_LEVEL;
                        paddr_q <= '0;
                     end else if (!perm_allow) begin
                        cause_q <= CZ_PERM;
                        paddr_q <= '0;
                     end else begin
                        cause_q <= CZ_NONE;
                        paddr_q <= va_q;
                     end
                  end else if (lvl_q == LVL_W'(1)) begin
                     cause_q <= CZ_NONE;
                     paddr_q <= {frame, va_q[PAGE_BITS-1:0]};
                     state_q <= ST_DONE;
                  end else begin
                     base_q <= {frame, {PAGE_BITS{1'b0}}};
                     lvl_q  <= lvl_q - LVL_W'(1);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = state_q == ST_IDLE;
   assign walking    = state_q == ST_WALK;
   assign resp_valid = state_q == ST_DONE;
   assign resp_paddr = paddr_q;
   assign resp_cause = cause_q;
   assign resp_fault = cause_q != CZ_NONE;

endmodule

// File: rtl/pgw_top.sv
module pgw_top
   import pgw_pkg::*;
#(
   parameter int ADDR_W      = 48,
   parameter int PAGE_BITS   = 12,
   parameter int IDX_W       = 9,
   parameter int LEVELS      = 4,
   parameter int ENTRY_W     = 64,
   parameter int NDESC       = 16,
   parameter int DESC_LSB    = 32,
   parameter int PE_MIN_LVL  = 2,
   parameter int PE_MAX_LVL  = 3,
   parameter int PRESENT_BIT = 0,
   parameter int KIND_BIT    = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  root_ptr,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_vaddr,
   input  logic [1:0]         req_access,
   output logic               mem_req_valid,
   output logic [ADDR_W-1:0]  mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [ENTRY_W-1:0] mem_rsp_data,
   output logic               resp_valid,
   output logic [ADDR_W-1:0]  resp_paddr,
   output logic               resp_fault,
   output logic [1:0]         resp_cause
);

   localparam int LVL_W     = $clog2(LEVELS + 1);
   localparam int ENT_SHIFT = $clog2(ENTRY_W / 8);

   if (ADDR_W != PAGE_BITS + IDX_W * LEVELS) begin : g_bad_addr
      $error("address width must equal page bits plus all index fields");
   end
   if ((1 << $clog2(NDESC)) != NDESC) begin : g_bad_ndesc
      $error("descriptor count must be a power of two");
   end
   if (DESC_LSB + 2 * NDESC > ENTRY_W) begin : g_bad_desc
      $error("descriptor field does not fit in an entry");
   end
   if (PE_MIN_LVL < 2 || PE_MAX_LVL >= LEVELS || PE_MIN_LVL > PE_MAX_LVL) begin : g_bad_pe
      $error("permission entry levels out of range");
   end
   if (PRESENT_BIT == KIND_BIT || KIND_BIT >= PAGE_BITS || PRESENT_BIT >= PAGE_BITS) begin : g_bad_flags
      $error("flag bits must be distinct and below the frame field");
   end

   logic [ADDR_W-1:0] va_q, base_q;
   access_e           acc_q;
   logic [LVL_W-1:0]  lvl_q;
   logic [IDX_W-1:0]  idx;
   logic              walking, perm_level_ok, perm_allow;

   pgw_index_sel #(
      .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W),
      .LEVELS(LEVELS), .LVL_W(LVL_W)
   ) u_idx (
      .va(va_q), .level(lvl_q), .idx(idx)
   );

   pgw_perm_check #(
      .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W), .LVL_W(LVL_W),
      .NDESC(NDESC), .PE_MIN_LVL(PE_MIN_LVL), .PE_MAX_LVL(PE_MAX_LVL)
   ) u_perm (
      .va(va_q), .level(lvl_q),
      .desc_field(mem_rsp_data[DESC_LSB +: 2*NDESC]),
      .access(acc_q), .level_ok(perm_level_ok), .allow(perm_allow)
   );

   pgw_walk_fsm #(
      .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .LEVELS(LEVELS), .LVL_W(LVL_W),
      .ENTRY_W(ENTRY_W), .PRESENT_BIT(PRESENT_BIT), .KIND_BIT(KIND_BIT)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .root_ptr(root_ptr),
      .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_access(access_e'(req_access)), .req_ready(req_ready),
      .walking(walking), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .perm_level_ok(perm_level_ok),
      .perm_allow(perm_allow), .va_q(va_q), .acc_q(acc_q), .lvl_q(lvl_q),
      .base_q(base_q), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
      .resp_fault(resp_fault), .resp_cause(resp_cause)
   );

   assign mem_req_valid = walking;
   assign mem_req_addr  = base_q + (ADDR_W'(idx) << ENT_SHIFT);

endmodule

// File: rtl/pgw_chk.sv
module pgw_chk #(
   parameter int ADDR_W = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              mem_req_valid,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              mem_rsp_valid,
   input logic              resp_valid,
   input logic [ADDR_W-1:0] resp_paddr,
   input logic              resp_fault
);

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_rsp_valid |=> mem_req_valid && $stable(mem_req_addr));

   // R2
   walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> mem_req_valid);

   // R9
   resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid && req_ready);

   // R9
   busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && mem_req_valid) && !(resp_valid && mem_req_valid));

   // R9
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && resp_fault |-> resp_paddr == '0);

endmodule

bind pgw_top pgw_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
   .mem_rsp_valid(mem_rsp_valid), .resp_valid(resp_valid),
   .resp_paddr(resp_paddr), .resp_fault(resp_fault)
);

// File: tb/sim_pgw_top.sv
module sim_pgw_top;

   localparam int K_LEAF = 0;
   localparam int K_NP   = 1;
   localparam int K_PE   = 2;
   localparam int WD     = 500;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [47:0] root_ptr;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [47:0] req_vaddr = '0;
   logic [1:0]  req_access = '0;
   logic        mem_req_valid;
   logic [47:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        resp_valid;
   logic [47:0] resp_paddr;
   logic        resp_fault;
   logic [1:0]  resp_cause;

   always #10 clk = ~clk;

   pgw_top u0 (
      .clk(clk), .rst_n(rst_n), .root_ptr(root_ptr),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_access(req_access),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .resp_valid(resp_valid), .resp_paddr(resp_paddr),
      .resp_fault(resp_fault), .resp_cause(resp_cause)
   );

   logic [63:0] mem [logic [47:0]];
   int n_checks = 0;
   int n_fail   = 0;
   int reads    = 0;
   int lat      = 0;

   function automatic logic [47:0] tbase(int lv);
      return 48'h10_0000 * 48'(lv);
   endfunction

   function automatic int vidx(logic [47:0] va, int lv);
      return int'((va >> (12 + 9 * (lv - 1))) & 48'h1ff);
   endfunction

   assign root_ptr = tbase(4);

   // memory model with 0..2 cycles of latency
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_rsp_valid = 1'b0;
         lat = 0;
      end else if (mem_rsp_valid) begin
         mem_rsp_valid = 1'b0;
      end else if (mem_req_valid) begin
         if (lat == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
            reads++;
            lat = $urandom_range(0, 2);
         end else begin
            lat--;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // lay out the tables for one walk, with decoy permission entries nearby
   task automatic build(input logic [47:0] va, input int kind, input int stop,
                        input logic [31:0] desc, input logic [35:0] frame);
      mem.delete();
      for (int lv = 4; lv >= stop; lv--) begin
         logic [47:0] a;
         int          k;
         a = tbase(lv) + 48'(vidx(va, lv)) * 48'd8;
         k = (vidx(va, lv) + 1 + $urandom_range(0, 100)) % 512;
         mem[tbase(lv) + 48'(k) * 48'd8] = {$urandom, $urandom} | 64'h3;
         if (lv > stop)
            mem[a] = {16'h0, tbase(lv - 1)} | 64'h1;
         else if (kind == K_LEAF)
            mem[a] = {16'h0, frame, 12'h0} | 64'h1;
         else if (kind == K_PE)
            mem[a] = {desc, 30'h0, 2'b11};
         else
            mem[a] = {$urandom, $urandom} & ~64'h1;
      end
   endtask

   task automatic run(input logic [47:0] va, input int kind, input int stop,
                      input logic [1:0] acc, input logic [31:0] desc,
                      input logic [35:0] frame, input bit hold, input string tag);
      logic [47:0] ep;
      logic [1:0]  ec;
      int          er;
      int          cyc;
      logic [1:0]  d;
      int          sel;
      bit          ok;
      build(va, kind, stop, desc, frame);
      ep = '0;
      er = (kind == K_LEAF) ? 4 : 5 - stop;
      if (kind == K_LEAF) begin
         ec = 2'd0; ep = {frame, va[11:0]};
      end else if (kind == K_NP) begin
         ec = 2'd1;
      end else if (stop != 2 && stop != 3) begin
         ec = 2'd3;
      end else begin
         sel = (stop == 2) ? int'(va[20:17]) : int'(va[29:26]);
         d   = desc[2*sel +: 2];
         ok  = (acc == 2'b00) ? (d != 2'b00) :
               (acc == 2'b01) ? (d == 2'b10) :
               (acc == 2'b10) ? (d == 2'b11) : 1'b0;
         ec = ok ? 2'd0 : 2'd2;
         ep = ok ? va : 48'h0;
      end
      @(negedge clk);
      reads = 0;
      req_valid = 1'b1; req_vaddr = va; req_access = acc;
      @(negedge clk);
      if (hold) begin
         req_vaddr = ~va; req_access = ~acc;
         check(req_ready == 1'b0, "R9 busy ready", 64'(req_ready), 64'h0);
      end else begin
         req_valid = 1'b0;
      end
      cyc = 0;
      while (!resp_valid && cyc < WD) begin
         @(negedge clk);
         cyc++;
      end
      req_valid = 1'b0;
      if (!resp_valid) begin
         check(1'b0, {tag, " watchdog"}, 64'(cyc), 64'(WD));
         do_reset();
      end else begin
         check(resp_paddr == ep, {tag, " paddr"}, 64'(resp_paddr), 64'(ep));
         check(resp_cause == ec, {tag, " cause"}, 64'(resp_cause), 64'(ec));
         check(resp_fault == (ec != 2'd0), "R9 fault flag", 64'(resp_fault), 64'(ec != 2'd0));
         check(reads == er, "R2 read count", 64'(reads), 64'(er));
         @(negedge clk);
         check(resp_valid == 1'b0 && req_ready == 1'b1, "R9 pulse", 64'(resp_valid), 64'h0);
      end
   endtask

   initial begin
      logic [47:0] va;
      void'($urandom(32'd2024));
      do_reset();
      // R1 reset state
      check(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'h1);
      check(mem_req_valid == 1'b0, "R1 mem idle", 64'(mem_req_valid), 64'h0);
      check(resp_valid == 1'b0, "R1 resp idle", 64'(resp_valid), 64'h0);

      // R3 normal leaf at level 1
      run(48'h7fab_cdef_1234, K_LEAF, 1, 2'b01, '0, 36'hfedcb_a987, 1'b0, "R3 leaf");
      // R4 not present at each level
      for (int lv = 1; lv <= 4; lv++)
         run({$urandom, $urandom}, K_NP, lv, 2'b00, '0, '0, 1'b0, "R4 not present");
      // R7 permission entry at illegal levels
      run(48'h1234_5678_9abc, K_PE, 1, 2'b00, 32'h5555_5555, '0, 1'b0, "R7 level1");
      run(48'h1234_5678_9abc, K_PE, 4, 2'b00, 32'h5555_5555, '0, 1'b0, "R7 level4");
      // R5 / R6 / R8: every descriptor code crossed with every access code
      for (int lv = 2; lv <= 3; lv++)
         for (int dc = 0; dc < 4; dc++)
            for (int ac = 0; ac < 4; ac++) begin
               va = {$urandom, $urandom};
               run(va, K_PE, lv, 2'(ac), {16{2'(dc)}}, '0, 1'b0,
                   lv == 2 ? "R5 R8 level2" : "R6 R8 level3");
            end
      // R5 hole among read-write descriptors, selected by vaddr[20:17]
      run(48'h0000_0006_0000, K_PE, 2, 2'b00, 32'hAAAA_AAAA & ~(32'h3 << 6), '0, 1'b0, "R5 hole");
      run(48'h0000_0008_0000, K_PE, 2, 2'b01, 32'hAAAA_AAAA & ~(32'h3 << 6), '0, 1'b0, "R5 beside hole");
      // R6 hole selected by vaddr[29:26]
      run(48'h0000_3c00_0000, K_PE, 3, 2'b00, 32'h3FFF_FFFF, '0, 1'b0, "R6 hole");
      // R9 request held high while busy
      run(48'h0abc_0002_0000, K_PE, 2, 2'b00, 32'hFFFF_FFFF, '0, 1'b1, "R9 hold");
      run(48'h0555_1234_5678, K_LEAF, 1, 2'b10, '0, 36'h1_2345, 1'b1, "R9 hold leaf");
      // random mix
      for (int n = 0; n < 300; n++) begin
         int kind, stop;
         kind = $urandom_range(0, 2);
         stop = (kind == K_LEAF) ? 1 :
                (kind == K_NP) ? $urandom_range(1, 4) :
                ($urandom_range(0, 4) == 0 ? $urandom_range(1, 4) : $urandom_range(2, 3));
         run({$urandom, $urandom}, kind, stop, 2'($urandom_range(0, 3)),
             $urandom, 36'({$urandom, $urandom}), 1'($urandom_range(0, 1)),
             kind == K_LEAF ? "R3 random" : kind == K_NP ? "R4 random" : "R8 random");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule